// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit virtual address into a real address. It reads translation tables held in memory, one 64-bit entry at a time, over a simple request/response port. A 64-bit control word gives the origin of the top table, the level the walk starts at (region-first, region-second, region-third or segment) and a 2-bit table length. The walk descends through the remaining region levels, then the segment level, and normally ends at a page table. A 1 MB large frame can end it one level early. Every entry is checked on the way, and write protection is collected as the walk goes down.

A request is accepted only while the walker is idle. The result comes back as a one-cycle pulse. It carries the real address, a write-allowed flag and a 6-bit exception code, where zero means the translation succeeded. A control word that marks a real space bypasses the tables. Enhanced mode is a per-request input. It turns on large frames and makes the region-level protection bits take effect.

Virtual address layout: region-first index [63:53], region-second [52:42], region-third [41:31], segment [30:20], page [19:12]. The top part of an 11-bit index is its two upper bits. Entries are 8 bytes, so an entry's address is its table origin plus the index times 8.

Top module: `dat_walker`

## Requirements
- R1: If control-word bit 5 (real space) is set, no table is read. The result follows one cycle after acceptance with real address equal to the virtual address, writable 1 and code 0.
- R2: Control word layout: origin [63:12], type [3:2] (3 = region-first, 2 = region-second, 1 = region-third, 0 = segment), length [1:0]. The first read goes to origin + start index * 8. Region entries point to the next table through bits [63:12], segment entries to the page table through bits [63:11]. The entry address is always 8-byte aligned.
- R3: Before any read, a start-level index top part greater than the control-word length raises that level's code. When the walk starts below region-first, any nonzero address bit above the start index raises code 0x38.
- R4: Invalid bit 5 set in a region or segment entry raises the code of that level: region-first 0x39, region-second 0x3A, region-third 0x3B, segment 0x10.
- R5: A region or segment entry whose type field [3:2] differs from the level being read raises 0x12. The values are those of R2.
- R6: A region entry holds a table offset [7:6] and a table length [1:0]. If the next level's index top part is below the offset or above the length, the next level's code is raised.
- R7: Protection bit 9 clears write permission in segment and page entries always, and in region entries only when enhanced mode is on.
- R8: A segment entry with common bit 4 set, under a control word with private bit 8 set, raises 0x12.
- R9: With enhanced mode on and segment bit 10 set, the real address is entry[63:20] joined with virtual bits [19:0], and the page table is not read. With enhanced mode off, bit 10 is ignored.
- R10: In a page entry, bit 10 set raises 0x11. Otherwise bit 11 set raises 0x12. Otherwise the real address is entry[63:12] with the low 12 bits zero, and the code is 0.
- R11: A read response flagged as an error stops the walk with code 0x05.
- R12: At most one read is outstanding. The result is a one-cycle pulse. On any nonzero code the real address and writable are zero. Requests seen while busy are ignored.
- R13: Each table read costs two cycles when the memory answers in the cycle after the request, so the result appears 2*n cycles after acceptance for n reads (at most five).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_vaddr | input | 64 | Virtual address |
| req_ctl | input | 64 | Control word |
| req_edat | input | 1 | Enhanced mode enable |
| busy | output | 1 | Walker not idle |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Read response |
| mem_rsp_err | input | 1 | Read failed |
| mem_rsp_data | input | 64 | Entry value |
| res_valid | output | 1 | Result pulse |
| res_raddr | output | 64 | Real address |
| res_writable | output | 1 | Write allowed |
| res_exc | output | 6 | Exception code, 0 on success |

## Verification
A real-space bypass or a failed pre-check is due one cycle after the accepting edge. Each table read adds two cycles when memory answers one cycle after the request, so a walk of n reads reports 2*n edges after acceptance. The bench counts falling edges from acceptance up to the result pulse and compares that count with twice the number of reads the requirements imply. It samples at falling edges only. Sweeps cover every start level, both enhanced settings and every fault type at every level.

// File: rtl/walk_pkg.sv
`timescale 1ns/1ps
package walk_pkg;
  parameter int VA_W   = 64;
  parameter int ENT_W  = 64;
  parameter int IDX_W  = 11;
  parameter int PX_W   = 8;
  parameter int PG_SH  = 12;
  parameter int ENT_SH = 3;
  parameter int EXC_W  = 6;
  parameter int LVL_W  = 3;
  parameter int TOP_W  = 2;

  localparam int IDX_BASE  = PG_SH + PX_W;   // first region/segment index bit
  localparam int PT_ORG_SH = PX_W + ENT_SH;  // page table alignment

  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LV_PAGE = 3'd0;
  localparam lvl_t LV_SEG  = 3'd1;
  localparam lvl_t LV_R3   = 3'd2;
  localparam lvl_t LV_R2   = 3'd3;
  localparam lvl_t LV_R1   = 3'd4;

  // control word fields
  localparam int CW_LEN  = 0;
  localparam int CW_TYPE = 2;
  localparam int CW_REAL = 5;
  localparam int CW_PRIV = 8;
  // region / segment entry fields
  localparam int E_LEN  = 0;
  localparam int E_TYPE = 2;
  localparam int E_CS   = 4;
  localparam int E_INV  = 5;
  localparam int E_OFF  = 6;
  localparam int E_PROT = 9;
  localparam int E_FC   = 10;
  // page entry fields
  localparam int P_PROT = 9;
  localparam int P_INV  = 10;
  localparam int P_MBZ  = 11;

  localparam logic [EXC_W-1:0] EXC_OK    = 6'h00;
  localparam logic [EXC_W-1:0] EXC_ADDR  = 6'h05;
  localparam logic [EXC_W-1:0] EXC_SEG   = 6'h10;
  localparam logic [EXC_W-1:0] EXC_PAGE  = 6'h11;
  localparam logic [EXC_W-1:0] EXC_SPEC  = 6'h12;
  localparam logic [EXC_W-1:0] EXC_RANGE = 6'h38;
  localparam logic [EXC_W-1:0] EXC_R1    = 6'h39;
  localparam logic [EXC_W-1:0] EXC_R2    = 6'h3A;
  localparam logic [EXC_W-1:0] EXC_R3    = 6'h3B;

  typedef enum logic [2:0] {
    S_IDLE, S_R1, S_R2, S_R3, S_SEG, S_PAGE, S_WAIT, S_DONE
  } state_t;

  function automatic logic [IDX_W-1:0] idx_of(input logic [VA_W-1:0] va, input lvl_t lvl);
    logic [VA_W-1:0] s;
    if (lvl == LV_PAGE) begin
      s = va >> PG_SH;
      return {{(IDX_W-PX_W){1'b0}}, s[PX_W-1:0]};
    end
    s = va >> (IDX_BASE + (int'(lvl) - 1) * IDX_W);
    return s[IDX_W-1:0];
  endfunction

  function automatic logic [TOP_W-1:0] idx_top(input logic [VA_W-1:0] va, input lvl_t lvl);
    logic [IDX_W-1:0] i;
    i = idx_of(va, lvl);
    return i[IDX_W-1 -: TOP_W];
  endfunction

  function automatic logic [EXC_W-1:0] lvl_exc(input lvl_t lvl);
    case (lvl)
      LV_R1:   return EXC_R1;
      LV_R2:   return EXC_R2;
      LV_R3:   return EXC_R3;
      LV_SEG:  return EXC_SEG;
      default: return EXC_PAGE;
    endcase
  endfunction

  function automatic state_t lvl_state(input lvl_t lvl);
    case (lvl)
      LV_R1:   return S_R1;
      LV_R2:   return S_R2;
      LV_R3:   return S_R3;
      LV_SEG:  return S_SEG;
      default: return S_PAGE;
    endcase
  endfunction
endpackage

// File: rtl/walk_start.sv
`timescale 1ns/1ps
// Pre-walk check of the control word against the virtual address.
module walk_start
  import walk_pkg::*;
(
  input  logic [VA_W-1:0]  vaddr,
  input  logic [ENT_W-1:0] ctl,
  output logic [EXC_W-1:0] exc,
  output lvl_t             lvl,
  output logic [VA_W-1:0]  gaddr
);
  logic [VA_W-1:0] above;
  logic            unused_in;

  assign unused_in = ^{ctl, vaddr};

  always_comb begin
    lvl   = lvl_t'(ctl[CW_TYPE +: 2]) + lvl_t'(1);
    above = vaddr >> (IDX_BASE + int'(lvl) * IDX_W);
    exc   = EXC_OK;
    if (|above)
      exc = EXC_RANGE;
    else if (idx_top(vaddr, lvl) > ctl[CW_LEN +: TOP_W])
      exc = lvl_exc(lvl);
    gaddr = {ctl[VA_W-1:PG_SH], {PG_SH{1'b0}}}
          + VA_W'({idx_of(vaddr, lvl), {ENT_SH{1'b0}}});
  end
endmodule

// File: rtl/walk_eval.sv
`timescale 1ns/1ps
// Checks one fetched entry and derives the next address or the result.
module walk_eval
  import walk_pkg::*;
(
  input  lvl_t             lvl,
  input  logic [ENT_W-1:0] ent,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             edat,
  input  logic             priv,
  output logic [EXC_W-1:0] exc,
  output logic             last,
  output logic             clr_wr,
  output logic [VA_W-1:0]  next_addr,
  output logic [VA_W-1:0]  raddr
);
  lvl_t             nlvl;
  logic [TOP_W-1:0] ntop;
  logic             unused_in;

  assign unused_in = ^{ent, vaddr};

  always_comb begin
    exc       = EXC_OK;
    last      = 1'b0;
    clr_wr    = 1'b0;
    next_addr = '0;
    raddr     = '0;
    nlvl      = lvl - lvl_t'(1);
    ntop      = idx_top(vaddr, nlvl);
    if (lvl >= LV_R3) begin
      if (ent[E_INV])
        exc = lvl_exc(lvl);
      else if (ent[E_TYPE +: 2] != nlvl[1:0])
        exc = EXC_SPEC;
      else if (ntop < ent[E_OFF +: TOP_W] || ntop > ent[E_LEN +: TOP_W])
        exc = lvl_exc(nlvl);
      clr_wr    = edat & ent[E_PROT];
      next_addr = {ent[VA_W-1:PG_SH], {PG_SH{1'b0}}}
                + VA_W'({idx_of(vaddr, nlvl), {ENT_SH{1'b0}}});
    end else if (lvl == LV_SEG) begin
      if (ent[E_INV])
        exc = EXC_SEG;
      else if (ent[E_TYPE +: 2] != 2'd0)
        exc = EXC_SPEC;
      else if (ent[E_CS] && priv)
        exc = EXC_SPEC;
      clr_wr = ent[E_PROT];
      if (edat && ent[E_FC]) begin
        last  = 1'b1;
        raddr = {ent[VA_W-1:IDX_BASE], vaddr[IDX_BASE-1:0]};
      end else begin
        next_addr = {ent[VA_W-1:PT_ORG_SH], {PT_ORG_SH{1'b0}}}
                  + VA_W'({idx_of(vaddr, LV_PAGE), {ENT_SH{1'b0}}});
      end
    end else begin
      if (ent[P_INV])
        exc = EXC_PAGE;
      else if (ent[P_MBZ])
        exc = EXC_SPEC;
      clr_wr = ent[P_PROT];
      last   = 1'b1;
      raddr  = {ent[VA_W-1:PG_SH], {PG_SH{1'b0}}};
    end
  end
endmodule

// File: rtl/dat_walker.sv
`timescale 1ns/1ps
module dat_walker
  import walk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [ENT_W-1:0] req_ctl,
  input  logic             req_edat,
  output logic             busy,
  output logic             mem_req_valid,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             res_valid,
  output logic [VA_W-1:0]  res_raddr,
  output logic             res_writable,
  output logic [EXC_W-1:0] res_exc
);
  state_t           state_q;
  lvl_t             lvl_q;
  logic [VA_W-1:0]  vaddr_q, gaddr_q, raddr_q;
  logic             priv_q, edat_q, wr_q;
  logic [EXC_W-1:0] exc_q;

  logic [EXC_W-1:0] st_exc;
  lvl_t             st_lvl;
  logic [VA_W-1:0]  st_gaddr;

  logic [EXC_W-1:0] ev_exc;
  logic             ev_last, ev_clr;
  logic [VA_W-1:0]  ev_next, ev_raddr;

  walk_start start_i (
    .vaddr (req_vaddr),
    .ctl   (req_ctl),
    .exc   (st_exc),
    .lvl   (st_lvl),
    .gaddr (st_gaddr)
  );

  walk_eval eval_i (
    .lvl       (lvl_q),
    .ent       (mem_rsp_data),
    .vaddr     (vaddr_q),
    .edat      (edat_q),
    .priv      (priv_q),
    .exc       (ev_exc),
    .last      (ev_last),
    .clr_wr    (ev_clr),
    .next_addr (ev_next),
    .raddr     (ev_raddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      lvl_q   <= LV_PAGE;
      vaddr_q <= '0;
      gaddr_q <= '0;
      raddr_q <= '0;
      priv_q  <= 1'b0;
      edat_q  <= 1'b0;
      wr_q    <= 1'b0;
      exc_q   <= EXC_OK;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            priv_q  <= req_ctl[CW_PRIV];
            edat_q  <= req_edat;
            wr_q    <= 1'b1;
            if (req_ctl[CW_REAL]) begin
              raddr_q <= req_vaddr;
              exc_q   <= EXC_OK;
              state_q <= S_DONE;
            end else if (st_exc != EXC_OK) begin
              raddr_q <= '0;
              wr_q    <= 1'b0;
              exc_q   <= st_exc;
              state_q <= S_DONE;
            end else begin
              gaddr_q <= st_gaddr;
              lvl_q   <= st_lvl;
              state_q <= lvl_state(st_lvl);
            end
          end
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err || ev_exc != EXC_OK) begin
              raddr_q <= '0;
              wr_q    <= 1'b0;
              exc_q   <= mem_rsp_err ? EXC_ADDR : ev_exc;
              state_q <= S_DONE;
            end else if (ev_last) begin
              raddr_q <= ev_raddr;
              wr_q    <= wr_q & ~ev_clr;
              exc_q   <= EXC_OK;
              state_q <= S_DONE;
            end else begin
              gaddr_q <= ev_next;
              wr_q    <= wr_q & ~ev_clr;
              lvl_q   <= lvl_q - lvl_t'(1);
              state_q <= lvl_state(lvl_q - lvl_t'(1));
            end
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_WAIT;
      endcase
    end
  end

  assign busy          = (state_q != S_IDLE);
  assign mem_req_valid = (state_q == S_R1) || (state_q == S_R2) || (state_q == S_R3) ||
                         (state_q == S_SEG) || (state_q == S_PAGE);
  assign mem_req_addr  = gaddr_q;
  assign res_valid     = (state_q == S_DONE);
  assign res_raddr     = raddr_q;
  assign res_writable  = wr_q;
  assign res_exc       = exc_q;
endmodule

// File: rtl/walk_checker.sv
`timescale 1ns/1ps
module walk_checker
  import walk_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [ENT_W-1:0] req_ctl,
  input logic             req_edat,
  input logic             busy,
  input logic             mem_req_valid,
  input logic [VA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             mem_rsp_err,
  input logic [ENT_W-1:0] mem_rsp_data,
  input logic             res_valid,
  input logic [VA_W-1:0]  res_raddr,
  input logic             res_writable,
  input logic [EXC_W-1:0] res_exc
);
  logic [2:0] rd_cnt;
  logic       unused_chk;

  assign unused_chk = ^{req_edat, mem_rsp_data, req_ctl};

  always_ff @(posedge clk) begin
    if (rst)                rd_cnt <= '0;
    else if (res_valid)     rd_cnt <= '0;
    else if (mem_req_valid) rd_cnt <= rd_cnt + 3'd1;
  end

  assert_real_bypass_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_ctl[CW_REAL]) |=>
      (res_valid && res_exc == EXC_OK && res_writable && res_raddr == $past(req_vaddr)));

  assert_entry_align_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[ENT_SH-1:0] == '0));

  assert_addr_err_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rsp_valid && mem_rsp_err) |=> (res_valid && res_exc == EXC_ADDR));

  assert_one_read_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  assert_res_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_fault_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_exc != EXC_OK) |-> (res_raddr == '0 && !res_writable));

  assert_read_bound_R13: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (rd_cnt <= 3'd5));
endmodule

bind dat_walker walk_checker chk_i (.*);

// File: tb/dat_walker_tb_top.sv
`timescale 1ns/1ps
module dat_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [63:0] req_ctl = '0;
  logic        req_edat = 1'b0;
  logic        busy, mem_req_valid, res_valid, res_writable;
  logic [63:0] mem_req_addr, res_raddr;
  logic        rsp_v = 1'b0, rsp_e = 1'b0;
  logic [63:0] rsp_d = '0;
  logic [5:0]  res_exc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [63:0] mem_a [0:4];
  logic [63:0] mem_d [0:4];
  logic        mem_e [0:4];
  logic [63:0] va, ctl;
  logic        edat;

  localparam logic [63:0] PFRAME = 64'h0000_0012_3456_7000;
  localparam logic [63:0] LFRAME = 64'h0000_0003_4560_0000;

  always #2.5 clk = ~clk;

  dat_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ctl(req_ctl), .req_edat(req_edat), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(rsp_v), .mem_rsp_err(rsp_e), .mem_rsp_data(rsp_d),
    .res_valid(res_valid), .res_raddr(res_raddr),
    .res_writable(res_writable), .res_exc(res_exc)
  );

  // memory model: answers one cycle after each request, unknown address = error
  always @(posedge clk) begin
    rsp_v <= mem_req_valid && !rst;
    rsp_d <= '0;
    rsp_e <= 1'b1;
    for (int i = 0; i < 5; i++)
      if (mem_a[i] == mem_req_addr) begin
        rsp_d <= mem_d[i];
        rsp_e <= mem_e[i];
      end
  end

  function automatic logic [63:0] torg(input int f);
    case (f)
      4: return 64'h10000;
      3: return 64'h20000;
      2: return 64'h30000;
      1: return 64'h40000;
      default: return 64'h0000_0003_4560_0800;
    endcase
  endfunction

  function automatic logic [10:0] lidx(input int f);
    case (f)
      4: return 11'h204;
      3: return 11'h201;
      2: return 11'h202;
      1: return 11'h203;
      default: return 11'h021;
    endcase
  endfunction

  function automatic logic [5:0] inv_code(input int f);
    case (f)
      4: return 6'h39;
      3: return 6'h3A;
      2: return 6'h3B;
      1: return 6'h10;
      default: return 6'h11;
    endcase
  endfunction

  task automatic build(input int t);
    va = '0;
    if (t == 3) va[63:53] = lidx(4);
    if (t >= 2) va[52:42] = lidx(3);
    if (t >= 1) va[41:31] = lidx(2);
    va[30:20] = lidx(1);
    va[19:12] = lidx(0)[7:0];
    va[11:0]  = 12'hABC;
    ctl = torg(t + 1) | (64'(t) << 2) | 64'd3;
    for (int f = 0; f < 5; f++) begin
      mem_a[f] = torg(f) + 64'(lidx(f)) * 64'd8;
      mem_e[f] = 1'b0;
      if (f >= 2)      mem_d[f] = torg(f - 1) | (64'(f - 1) << 2) | 64'd3;
      else if (f == 1) mem_d[f] = torg(0);
      else             mem_d[f] = PFRAME;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [5:0] e_exc,
                     input logic [63:0] e_ra, input logic e_wr, input int reads);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_ctl = ctl; req_edat = edat;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!res_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    check(n == 2 * reads, tag, "latency (R13)", 64'(n), 64'(2 * reads));
    check(res_exc == e_exc, tag, "exception", 64'(res_exc), 64'(e_exc));
    check(res_raddr == e_ra, tag, "real address", res_raddr, e_ra);
    check(res_writable == e_wr, tag, "writable", 64'(res_writable), 64'(e_wr));
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 5; i++) begin
      mem_a[i] = '0; mem_d[i] = '0; mem_e[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(!busy && !res_valid && !mem_req_valid, "R12", "reset idle",
          64'({busy, res_valid, mem_req_valid}), 64'd0);

    for (int t = 0; t < 4; t++) begin
      for (int ed = 0; ed < 2; ed++) begin
        edat = ed[0];
        // R2 / R10 full walk succeeds
        build(t); run("R2", 6'h00, PFRAME, 1'b1, t + 2);
        for (int f = t + 1; f >= 0; f--) begin
          // R4 / R10 invalid entry at level f
          build(t);
          mem_d[f] = mem_d[f] | (f == 0 ? 64'h400 : 64'h20);
          run(f == 0 ? "R10" : "R4", inv_code(f), 64'd0, 1'b0, t + 2 - f);
          // R5 type mismatch, R10 must-be-zero bit
          build(t);
          mem_d[f] = mem_d[f] ^ (f == 0 ? 64'h800 : 64'h4);
          run(f == 0 ? "R10" : "R5", 6'h12, 64'd0, 1'b0, t + 2 - f);
          // R11 failed read
          build(t); mem_e[f] = 1'b1;
          run("R11", 6'h05, 64'd0, 1'b0, t + 2 - f);
          // R7 protection
          build(t); mem_d[f] = mem_d[f] | 64'h200;
          run("R7", 6'h00, PFRAME, (f >= 2 && !edat) ? 1'b1 : 1'b0, t + 2);
          if (f >= 2) begin
            // R6 offset above next index, then length below it
            build(t); mem_d[f] = mem_d[f] | 64'h80;
            run("R6", inv_code(f - 1), 64'd0, 1'b0, t + 2 - f);
            build(t); mem_d[f] = mem_d[f] & ~64'h3;
            run("R6", inv_code(f - 1), 64'd0, 1'b0, t + 2 - f);
          end
        end
        // R3 start index above the control-word length
        build(t); ctl = ctl & ~64'h3;
        run("R3", inv_code(t + 1), 64'd0, 1'b0, 0);
        if (t < 3) begin
          build(t); va[63] = 1'b1;
          run("R3", 6'h38, 64'd0, 1'b0, 0);
        end
        // R9 large frame
        build(t); mem_d[1] = mem_d[1] | 64'h400;
        if (edat) run("R9", 6'h00, LFRAME | 64'h21ABC, 1'b1, t + 1);
        else      run("R9", 6'h00, PFRAME, 1'b1, t + 2);
        // R8 common segment under private space, and without it
        build(t); mem_d[1] = mem_d[1] | 64'h10; ctl = ctl | 64'h100;
        run("R8", 6'h12, 64'd0, 1'b0, t + 1);
        build(t); mem_d[1] = mem_d[1] | 64'h10;
        run("R8", 6'h00, PFRAME, 1'b1, t + 2);
        // R1 real space
        build(t); ctl = ctl | 64'h20;
        run("R1", 6'h00, va, 1'b1, 0);
      end
    end

    // R12 request while busy is ignored
    build(3); edat = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_ctl = ctl; req_edat = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 64'h5555_0000; req_ctl = 64'h20;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 60 && !res_valid; k++) @(negedge clk);
    check(res_raddr == PFRAME && res_exc == 6'h00, "R12", "busy walk result",
          res_raddr, PFRAME);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!res_valid && !mem_req_valid, "R12", "no extra activity",
            64'({res_valid, mem_req_valid}), 64'd0);
    end
    summary();
  end
endmodule